// File: doc/BRIEF.md
# Serially Loaded Bank Window Mapper

This block gives a requester a 32 KB window into a 24-bit address space. The window's position comes from a bank base register that is loaded one bit at a time. Each write to the one-byte bank port moves the base one place toward the low end and puts bit 0 of the written byte into the top bit, bit 23. A mask keeps only bits 23 down to 15 of the base. Nine writes in a row therefore set the bank completely: the first bit written ends up in bit 15 and the last in bit 23.

The window port takes an access at a 15-bit offset and forwards it to a master port at the address base + offset. Reads and writes are forwarded the same way. The forwarding engine is a three-state machine with states FWD_IDLE, FWD_ISSUE and FWD_RESP:
- ACCEPT (FWD_IDLE to FWD_ISSUE) happens when `win_req` is seen. The translated address, direction and write data are latched at that moment.
- COMPLETE (FWD_ISSUE to FWD_RESP) happens on `mst_ack`. The read data is captured at the same edge.
- RELEASE (FWD_RESP to FWD_IDLE) is unconditional. During the one cycle in FWD_RESP, `win_ready` is high.

While the access is in flight, a requester keeps `win_req` high. It drops `win_req` after it sees `win_ready`.

Top module: `bank_window_mapper`

## Requirements
- R1: During and after reset the base is 0x000000, `mst_req` is 0 and `win_ready` is 0. An access at offset 0 made right after reset goes to master address 0x000000.
- R2: A bank write makes the new base as follows. Bit 23 becomes bit 0 of the written byte. Bits 22..15 take the old bits 23..16. The old bit 15 is lost.
- R3: Bits 7..1 of the written bank byte have no effect on the base.
- R4: Base bits 14..0 are always zero. After nine bank writes the base depends only on those nine bits: the first lands in bit 15 and the last in bit 23.
- R5: A window access at offset A (0..0x7FFF) appears on `mst_addr` as base + A. With base 0xFF8000 and A = 0x7FFF this is 0xFFFFFF.
- R6: `mst_we` and `mst_wdata` equal the `win_we` and `win_wdata` of the accepted access, for both reads (`win_we`=0) and writes (`win_we`=1).
- R7: `win_ready` stays 0 until the master acknowledges. It is then 1 for exactly one cycle, in the cycle after `mst_ack`. In that cycle `win_rdata` equals the `mst_rdata` given with the ack.
- R8: `mst_req` rises in the cycle after an access is accepted. It stays high, with `mst_addr` stable, until `mst_ack`, and it is low in the cycle after the ack.
- R9: A bank write in the same cycle that an access is accepted does not change that access's address. It applies to the next access.
- R10: Bank writes made while an access is in flight leave the in-flight `mst_addr` unchanged. They apply to later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_wr_en | input | 1 | Bank register write strobe |
| bank_wr_data | input | 8 | Bank write byte; only bit 0 is used |
| win_req | input | 1 | Window access request, held until `win_ready` |
| win_we | input | 1 | Window access direction, 1 = write |
| win_offset | input | 15 | Byte offset inside the window |
| win_wdata | input | 8 | Window write data |
| win_ready | output | 1 | One-cycle completion of a window access |
| win_rdata | output | 8 | Read data returned to the window |
| mst_req | output | 1 | Forwarded request to downstream memory |
| mst_we | output | 1 | Forwarded direction |
| mst_addr | output | 24 | Translated address, base + offset |
| mst_wdata | output | 8 | Forwarded write data |
| mst_ack | input | 1 | Downstream completion |
| mst_rdata | input | 8 | Downstream read data, valid with `mst_ack` |

## Verification
Three directed patterns each test one property of the base:
- A fixed nine-bit sequence, which can show whether bits move in from the top and in which order.
- Bytes whose low bit is the same but whose upper bits differ, which can show whether any bit other than bit 0 leaks into the base.
- The all-ones bank with the largest offset, which exercises the top of the address range.

Bank writes are also placed in the same cycle as an acceptance, and in the middle of an in-flight access, to test whether a base change reaches the current access or only later ones.

Random runs mix the number of bank writes, the data bytes, the offsets, the access direction and the acknowledge latency. They test the address sum and the pass-through of direction and data for reads and writes.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    // Forwarding engine states
    typedef enum logic [1:0] {
        FWD_IDLE  = 2'd0,
        FWD_ISSUE = 2'd1,
        FWD_RESP  = 2'd2
    } fwd_state_e;

endpackage

// File: rtl/bwm_bank_shifter.sv
module bwm_bank_shifter #(
    parameter int ADDR_W = 24,
    parameter int WIN_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base
);

    localparam int BANK_BITS = ADDR_W - WIN_W;
    localparam logic [ADDR_W-1:0] KEEP_MASK = {{BANK_BITS{1'b1}}, {WIN_W{1'b0}}};

    logic [ADDR_W-1:0] data_ext;
    logic [ADDR_W-1:0] base_nxt;

    // Upper data bits are shifted past the top and the mask removes the rest.
    always_comb begin
        data_ext = ADDR_W'(wr_data);
        base_nxt = ((base >> 1) | (data_ext << (ADDR_W - 1))) & KEEP_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0;
        end else if (wr_en) begin
            base <= base_nxt;
        end
    end

    // R2
    top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> base[ADDR_W-1] == $past(wr_data[0]));

    // R2
    shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> base[ADDR_W-2:WIN_W] == $past(base[ADDR_W-1:WIN_W+1]));

    // R4
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base[WIN_W-1:0] == '0);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(base));

endmodule

// File: rtl/bwm_addr_xlate.sv
module bwm_addr_xlate #(
    parameter int ADDR_W = 24,
    parameter int WIN_W  = 15
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [WIN_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        off_ext = ADDR_W'(offset);
        addr    = base + off_ext;
    end

    // R5
    always_comb begin
        window_span_chk: assert (addr[WIN_W-1:0] == offset || base[WIN_W-1:0] != '0);
    end

endmodule

// File: rtl/bwm_fwd_fsm.sv
module bwm_fwd_fsm
    import bwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_req,
    input  logic mst_ack,
    output logic accept,
    output logic complete,
    output logic mst_req,
    output logic win_ready
);

    fwd_state_e state, state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FWD_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: ACCEPT, COMPLETE, RELEASE
    always_comb begin
        state_nxt = state;
        unique case (state)
            FWD_IDLE:  if (win_req) state_nxt = FWD_ISSUE;
            FWD_ISSUE: if (mst_ack) state_nxt = FWD_RESP;
            FWD_RESP:  state_nxt = FWD_IDLE;
            default:   state_nxt = FWD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept    = 1'b0;
        complete  = 1'b0;
        mst_req   = 1'b0;
        win_ready = 1'b0;
        unique case (state)
            FWD_IDLE:  accept = win_req;
            FWD_ISSUE: begin
                mst_req  = 1'b1;
                complete = mst_ack;
            end
            FWD_RESP:  win_ready = 1'b1;
            default:   ;
        endcase
    end

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_ready |=> !win_ready);

    // R7
    ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && mst_ack) |=> win_ready);

    // R8
    req_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> mst_req);

    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && mst_ack) |=> !mst_req);

endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper #(
    parameter int ADDR_W = 24,
    parameter int WIN_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_wr_en,
    input  logic [DATA_W-1:0] bank_wr_data,
    input  logic              win_req,
    input  logic              win_we,
    input  logic [WIN_W-1:0]  win_offset,
    input  logic [DATA_W-1:0] win_wdata,
    output logic              win_ready,
    output logic [DATA_W-1:0] win_rdata,
    output logic              mst_req,
    output logic              mst_we,
    output logic [ADDR_W-1:0] mst_addr,
    output logic [DATA_W-1:0] mst_wdata,
    input  logic              mst_ack,
    input  logic [DATA_W-1:0] mst_rdata
);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] xlate_addr;
    logic              accept;
    logic              complete;

    bwm_bank_shifter #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W),
        .DATA_W (DATA_W)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr_en),
        .wr_data (bank_wr_data),
        .base    (base)
    );

    bwm_addr_xlate #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W)
    ) u_xlate (
        .base   (base),
        .offset (win_offset),
        .addr   (xlate_addr)
    );

    bwm_fwd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_req   (win_req),
        .mst_ack   (mst_ack),
        .accept    (accept),
        .complete  (complete),
        .mst_req   (mst_req),
        .win_ready (win_ready)
    );

    // Access latch: address is taken from the base before any same-edge bank write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst_addr  <= '0;
            mst_we    <= 1'b0;
            mst_wdata <= '0;
        end else if (accept) begin
            mst_addr  <= xlate_addr;
            mst_we    <= win_we;
            mst_wdata <= win_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_rdata <= '0;
        end else if (complete) begin
            win_rdata <= mst_rdata;
        end
    end

    // R8 R10
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && !mst_ack) |=> (mst_req && $stable(mst_addr) && $stable(mst_we)));

    // R7
    rdata_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && mst_ack) |=> win_rdata == $past(mst_rdata));

    // R9
    accept_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> mst_addr[ADDR_W-1:WIN_W] == $past(base[ADDR_W-1:WIN_W]));

endmodule

// File: tb/bank_window_mapper_tb.sv
module bank_window_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_wr_en = 1'b0;
    logic [7:0]  bank_wr_data = '0;
    logic        win_req = 1'b0;
    logic        win_we = 1'b0;
    logic [14:0] win_offset = '0;
    logic [7:0]  win_wdata = '0;
    logic        win_ready;
    logic [7:0]  win_rdata;
    logic        mst_req;
    logic        mst_we;
    logic [23:0] mst_addr;
    logic [7:0]  mst_wdata;
    logic        mst_ack = 1'b0;
    logic [7:0]  mst_rdata = '0;

    int checks = 0;
    int fails  = 0;
    logic [23:0] exp_base = '0;

    always #2 clk = ~clk;

    bank_window_mapper u_dut (
        .clk, .rst_n, .bank_wr_en, .bank_wr_data, .win_req, .win_we,
        .win_offset, .win_wdata, .win_ready, .win_rdata, .mst_req, .mst_we,
        .mst_addr, .mst_wdata, .mst_ack, .mst_rdata
    );

    function automatic logic [23:0] next_base(logic [23:0] b, logic [7:0] d);
        return ((b >> 1) | ({23'd0, d[0]} << 23)) & 24'hFF8000;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bank_write(logic [7:0] d);
        @(negedge clk);
        bank_wr_en   = 1'b1;
        bank_wr_data = d;
        @(negedge clk);
        bank_wr_en   = 1'b0;
        exp_base     = next_base(exp_base, d);
    endtask

    // One full window access; optional bank write in the accept cycle or mid-flight.
    task automatic access(logic [14:0] off, logic we, logic [7:0] wd, int lat,
                          bit wr_same, bit wr_mid, logic [7:0] bd, string req);
        logic [23:0] exp_addr;
        logic [7:0]  rd;
        exp_addr = exp_base + {9'd0, off};
        rd = 8'($urandom);
        @(negedge clk);
        win_req = 1'b1; win_we = we; win_offset = off; win_wdata = wd;
        if (wr_same) begin
            bank_wr_en = 1'b1; bank_wr_data = bd;
        end
        @(negedge clk);
        if (wr_same) begin
            bank_wr_en = 1'b0;
            exp_base = next_base(exp_base, bd);
        end
        chk(mst_req == 1'b1, "R8", 32'(mst_req), 1);
        chk(mst_addr == exp_addr, req, 32'(mst_addr), 32'(exp_addr));
        chk(mst_we == we && mst_wdata == wd, "R6", {23'd0, mst_we, mst_wdata}, {23'd0, we, wd});
        for (int i = 0; i < lat; i++) begin
            if (wr_mid && i == 0) begin
                bank_wr_en = 1'b1; bank_wr_data = bd;
            end
            @(negedge clk);
            if (wr_mid && i == 0) begin
                bank_wr_en = 1'b0;
                exp_base = next_base(exp_base, bd);
            end
            chk(mst_req && !win_ready && mst_addr == exp_addr, "R10",
                32'(mst_addr), 32'(exp_addr));
        end
        mst_ack = 1'b1; mst_rdata = rd;
        @(negedge clk);
        mst_ack = 1'b0; mst_rdata = '0;
        chk(win_ready == 1'b1 && win_rdata == rd, "R7", {23'd0, win_ready, win_rdata}, {23'd0, 1'b1, rd});
        chk(mst_req == 1'b0, "R8", 32'(mst_req), 0);
        win_req = 1'b0;
        @(negedge clk);
        chk(win_ready == 1'b0, "R7", 32'(win_ready), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [8:0] seq;
        void'($urandom(32'h1234ABCD));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mst_req == 1'b0 && win_ready == 1'b0, "R1", {30'd0, mst_req, win_ready}, 0);
        rst_n = 1'b1;
        access(15'd0, 1'b0, 8'h00, 0, 0, 0, 8'h00, "R1");

        // R4: fixed nine-bit pattern, first bit lands in bit 15
        seq = 9'b101100101;
        for (int i = 0; i < 9; i++) bank_write({7'd0, seq[8-i]});
        chk(exp_base == 24'hA68000, "R4", 32'(exp_base), 32'hA68000);
        access(15'd0, 1'b0, 8'h00, 1, 0, 0, 8'h00, "R4");

        // R3: upper data bits ignored
        bank_write(8'hFE);
        access(15'd0, 1'b0, 8'h00, 0, 0, 0, 8'h00, "R3");
        bank_write(8'h01);
        access(15'd0, 1'b0, 8'h00, 0, 0, 0, 8'h00, "R3");

        // R2: single shift
        bank_write(8'h81);
        access(15'h0010, 1'b1, 8'h5A, 0, 0, 0, 8'h00, "R2");

        // R5: top of range
        for (int i = 0; i < 9; i++) bank_write(8'hFF);
        access(15'h7FFF, 1'b1, 8'hC3, 2, 0, 0, 8'h00, "R5");
        chk(exp_base + 24'h7FFF == 24'hFFFFFF, "R5", 32'(exp_base + 24'h7FFF), 32'hFFFFFF);

        // R9: same-cycle bank write applies later
        access(15'h0123, 1'b0, 8'h00, 1, 1, 0, 8'h00, "R9");
        access(15'h0123, 1'b0, 8'h00, 0, 0, 0, 8'h00, "R9");

        // R10: mid-flight bank write
        access(15'h0042, 1'b1, 8'h11, 3, 0, 1, 8'h00, "R10");
        access(15'h0042, 1'b0, 8'h00, 0, 0, 0, 8'h00, "R10");

        // Random mix, R5 R6
        for (int n = 0; n < 60; n++) begin
            int nw;
            nw = int'($urandom_range(0, 10));
            for (int k = 0; k < nw; k++) bank_write(8'($urandom));
            access(15'($urandom), 1'($urandom), 8'($urandom), int'($urandom_range(0, 3)),
                   0, 0, 8'h00, "R5");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule